// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock timing for an I2C bus master. A programmable prescaler divides the functional clock into an internal tick, meant to be roughly 12 MHz for standard (100 kbit/s) and fast (400 kbit/s) operation. Two further settings give the length of the SCL low phase and the SCL high phase in internal ticks. Each length has a fixed offset built in: 7 ticks for low and 5 for high.

A byte-level sequencer drives the block. It holds a run request to keep clocking, a hold request to keep SCL low at the end of a low phase, and a release request that stops the clock with SCL released high at the next phase boundary. The block returns three things. The first is the SCL pull-down enable. The second is a strobe in the middle of each low phase, which marks when SDA may change. The third is a strobe in the middle of each high phase, which marks when SDA is sampled. The three timing settings are written through a small configuration port and are accepted only while the module is disabled. Clearing the module enable returns the logic to idle and keeps the settings.

Top module: `scl_clock_gen`

## Requirements
- R1: With a prescale setting P (0 to 255), every tick-based duration spans exactly P+1 functional clock cycles per tick, so a full SCL period lasts (L+H+12)*(P+1) cycles.
- R2: Each SCL low phase keeps `scl_drive_low` at 1 for exactly (L+7)*(P+1) cycles, where L is the low setting.
- R3: Each SCL high phase keeps `scl_drive_low` at 0 for exactly (H+5)*(P+1) cycles, where H is the high setting.
- R4: A configuration write stores `cfg_wdata` only while `mod_en` is 0. Selector 0 writes the prescale setting, 1 writes the low setting, and 2 writes the high setting. Selector 3 stores nothing. Writes made while `mod_en` is 1 are ignored.
- R5: Reset, or `mod_en` at 0, leaves SCL released (`scl_drive_low` at 0) with both strobes quiet, and clearing `mod_en` stops a running clock on the next cycle. The settings survive, so re-enabling gives the same timing as before.
- R6: From idle, with `mod_en` at 1, `seq_run` at 1 and `seq_rel` at 0, `scl_drive_low` goes to 1 one cycle after the request is sampled.
- R7: `sda_change_stb` pulses for one cycle exactly once per low phase. It falls in cycle floor((L+7)/2)*(P+1)+P, counting the first low cycle as 0.
- R8: `sda_sample_stb` pulses for one cycle exactly once per high phase. It falls in cycle floor((H+5)/2)*(P+1)+P, counting the first high cycle as 0.
- R9: If `seq_hold` is 1 and `seq_rel` is 0 when a low phase ends, SCL stays low with no further change strobe. Once hold drops, the low phase ends at the next tick. With P=0, SCL is released in the cycle after hold is seen low.
- R10: If `seq_rel` is 1 when any phase ends, the generator goes idle with SCL released. Release takes priority over hold. While release is held, no new low phase starts.
- R11: If `seq_run` is 0 when a high phase ends, the generator goes idle after completing that high phase in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Module enable; 0 holds the functional logic idle and allows configuration |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Setting selector: 0 prescale, 1 low, 2 high, 3 unused |
| cfg_wdata | input | 8 | Configuration write data |
| seq_run | input | 1 | Keep generating SCL periods |
| seq_hold | input | 1 | Hold SCL low at the end of the low phase |
| seq_rel | input | 1 | Stop at the next phase end with SCL released |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_change_stb | output | 1 | Mid-low-phase strobe: SDA may change |
| sda_sample_stb | output | 1 | Mid-high-phase strobe: sample SDA |

## Verification
Two situations are hard to reach from the ports: a phase boundary where hold and release are both asserted, and an enable drop partway through a low phase. The stimulus raises release and hold together on the first cycle of a low phase. It then counts the full low length before it expects idle, and it also looks for a restart once release falls. The enable is cleared two cycles into a low phase with run still asserted. Periods measured after re-enabling must match the earlier ones, which shows the settings were retained.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;

  // Generator phase; the encoding is local to this block.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Configuration selector codes.
  localparam logic [1:0] SEL_PRESCALE = 2'd0;
  localparam logic [1:0] SEL_LOW      = 2'd1;
  localparam logic [1:0] SEL_HIGH     = 2'd2;
  localparam int unsigned NUM_SETTINGS = 3;

  // Number of internal ticks in a phase for a given setting and fixed offset.
  function automatic int unsigned phase_ticks(input int unsigned setting,
                                              input int unsigned offset);
    return setting + offset;
  endfunction

  // Tick index inside a phase at which the mid-phase strobe fires.
  function automatic int unsigned mid_tick(input int unsigned ticks);
    return ticks / 2;
  endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
`timescale 1ns/1ps
module scl_cfg_regs
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [DIV_W-1:0] cfg_wdata,
  output logic [DIV_W-1:0] prescale_o,
  output logic [DIV_W-1:0] low_set_o,
  output logic [DIV_W-1:0] high_set_o
);

  logic [NUM_SETTINGS-1:0][DIV_W-1:0] set_q;
  logic                               wr_open;

  // Writes are accepted only while the module is disabled.
  assign wr_open = cfg_wr && !mod_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SETTINGS; i++) begin
        if (wr_open && cfg_sel == 2'(i)) set_q[i] <= cfg_wdata;
      end
    end
  end

  assign prescale_o = set_q[SEL_PRESCALE];
  assign low_set_o  = set_q[SEL_LOW];
  assign high_set_o = set_q[SEL_HIGH];

  // R4: settings cannot move while the module is enabled
  p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |=> $stable(set_q));

endmodule

// File: rtl/scl_prescaler.sv
`timescale 1ns/1ps
module scl_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == div_val);
  assign tick = !clr && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (wrap)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R1: the divide counter never runs past the programmed value
  p_psc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> cnt_q <= div_val);

  // R1: a tick restarts the division window
  p_psc_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == '0);

endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             seq_run,
  input  logic             seq_hold,
  input  logic             seq_rel,
  input  logic             tick,
  input  logic [DIV_W-1:0] low_set,
  input  logic [DIV_W-1:0] high_set,
  output scl_phase_e       phase_o,
  output logic             scl_drive_low,
  output logic             chg_stb,
  output logic             smp_stb,
  output logic             phase_end
);

  localparam int PH_W = $clog2((2 ** DIV_W) + LOW_OFS + HIGH_OFS);

  scl_phase_e      st_q, st_d;
  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] low_len, high_len, cur_len;
  logic [PH_W-1:0] low_mid, high_mid;
  logic            at_last;
  logic            start_ok;

  assign low_len  = PH_W'(phase_ticks(32'(low_set), LOW_OFS));
  assign high_len = PH_W'(phase_ticks(32'(high_set), HIGH_OFS));
  assign low_mid  = PH_W'(mid_tick(32'(low_len)));
  assign high_mid = PH_W'(mid_tick(32'(high_len)));
  assign cur_len  = (st_q == PH_HIGH) ? high_len : low_len;
  assign at_last  = (cnt_q == cur_len - 1'b1);
  assign phase_end = tick && at_last && (st_q != PH_IDLE);
  assign start_ok  = seq_run && !seq_rel;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE: if (start_ok) st_d = PH_LOW;
      PH_LOW: begin
        if (phase_end) begin
          if (seq_rel)       st_d = PH_IDLE;
          else if (seq_hold) st_d = PH_LOW;
          else               st_d = PH_HIGH;
        end
      end
      PH_HIGH: begin
        if (phase_end) begin
          if (seq_rel || !seq_run) st_d = PH_IDLE;
          else                     st_d = PH_LOW;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (!mod_en) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q || st_q == PH_IDLE) cnt_q <= '0;
      else if (tick && !at_last)           cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o       = st_q;
  assign scl_drive_low = (st_q == PH_LOW);
  assign chg_stb       = (st_q == PH_LOW)  && tick && (cnt_q == low_mid);
  assign smp_stb       = (st_q == PH_HIGH) && tick && (cnt_q == high_mid);

  // R2: a low phase hands over to high only after its full tick count
  p_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_HIGH && $past(st_q) == PH_LOW) |-> $past(cnt_q) == $past(low_len) - 1'b1);

  // R3: an enabled high phase leaves only after its full tick count
  p_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PH_HIGH && $past(st_q) == PH_HIGH && $past(mod_en))
      |-> $past(cnt_q) == $past(high_len) - 1'b1);

  // R5: disabling returns to idle with the phase counter cleared
  p_disabled_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (st_q == PH_IDLE && cnt_q == '0));

  // R6: a start request from idle begins a low phase next cycle
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE && mod_en && seq_run && !seq_rel) |=> st_q == PH_LOW);

  // R9: hold keeps SCL low at the end of the low phase
  p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && st_q == PH_LOW && phase_end && seq_hold && !seq_rel) |=> st_q == PH_LOW);

  // R10: release at a phase end always lands in idle
  p_release_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && seq_rel) |=> st_q == PH_IDLE);

endmodule

// File: rtl/scl_clock_gen.sv
`timescale 1ns/1ps
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [DIV_W-1:0] cfg_wdata,
  input  logic             seq_run,
  input  logic             seq_hold,
  input  logic             seq_rel,
  output logic             scl_drive_low,
  output logic             sda_change_stb,
  output logic             sda_sample_stb
);

  logic [DIV_W-1:0] prescale, low_set, high_set;
  logic             tick;
  logic             prescale_clr;
  logic             phase_end;
  scl_phase_e       phase;

  scl_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_en     (mod_en),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .prescale_o (prescale),
    .low_set_o  (low_set),
    .high_set_o (high_set)
  );

  // The divider restarts whenever no phase is running.
  assign prescale_clr = !mod_en || (phase == PH_IDLE);

  scl_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (prescale_clr),
    .div_val (prescale),
    .tick    (tick)
  );

  scl_phase_fsm #(
    .DIV_W    (DIV_W),
    .LOW_OFS  (LOW_OFS),
    .HIGH_OFS (HIGH_OFS)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .mod_en        (mod_en),
    .seq_run       (seq_run),
    .seq_hold      (seq_hold),
    .seq_rel       (seq_rel),
    .tick          (tick),
    .low_set       (low_set),
    .high_set      (high_set),
    .phase_o       (phase),
    .scl_drive_low (scl_drive_low),
    .chg_stb       (sda_change_stb),
    .smp_stb       (sda_sample_stb),
    .phase_end     (phase_end)
  );

  // R7: the change strobe only appears while SCL is pulled low
  p_chg_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |-> scl_drive_low && !prescale_clr);

  // R8: the sample strobe only appears during a released, running phase
  p_smp_in_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |-> !scl_drive_low && !prescale_clr);

  // R11: with run dropped, a high phase end goes idle
  p_run_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && phase == PH_HIGH && !seq_run) |=> !scl_drive_low && prescale_clr);

endmodule

// File: tb/tb_scl_clock_gen.sv
`timescale 1ns/1ps
module tb_scl_clock_gen;

  logic       clk = 1'b0;
  logic       rst_n, mod_en, cfg_wr;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic       seq_run, seq_hold, seq_rel;
  logic       scl_drive_low, sda_change_stb, sda_sample_stb;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  scl_clock_gen dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .mod_en         (mod_en),
    .cfg_wr         (cfg_wr),
    .cfg_sel        (cfg_sel),
    .cfg_wdata      (cfg_wdata),
    .seq_run        (seq_run),
    .seq_hold       (seq_hold),
    .seq_rel        (seq_rel),
    .scl_drive_low  (scl_drive_low),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] sel, input int val);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = 8'(val);
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic program_cfg(input int p, input int lo, input int hi);
    seq_run = 1'b0; mod_en = 1'b0;
    step();
    write_reg(2'd0, p);
    write_reg(2'd1, lo);
    write_reg(2'd2, hi);
    mod_en = 1'b1;
    step();
  endtask

  // Finds the next low phase start and measures one full period.
  task automatic measure(output int lowc, output int highc, output int chgi,
                         output int smpi, output int chgn, output int smpn);
    logic prev;
    lowc = 0; highc = 0; chgi = -1; smpi = -1; chgn = 0; smpn = 0;
    prev = scl_drive_low;
    while (1) begin
      step();
      if (!prev && scl_drive_low) break;
      prev = scl_drive_low;
    end
    while (scl_drive_low) begin
      if (sda_change_stb) begin chgn++; chgi = lowc; end
      if (sda_sample_stb) smpn++;
      lowc++;
      step();
    end
    while (!scl_drive_low) begin
      if (sda_sample_stb) begin smpn++; smpi = highc; end
      if (sda_change_stb) chgn++;
      highc++;
      step();
    end
  endtask

  task automatic check_period(input int p, input int lo, input int hi, input string tag);
    int lowc, highc, chgi, smpi, chgn, smpn;
    int tl, th;
    tl = lo + 7;
    th = hi + 5;
    measure(lowc, highc, chgi, smpi, chgn, smpn);
    check({"R2 low length ", tag}, lowc, tl * (p + 1));
    check({"R3 high length ", tag}, highc, th * (p + 1));
    check({"R1 full period ", tag}, lowc + highc, (lo + hi + 12) * (p + 1));
    check({"R7 change strobe position ", tag}, chgi, (tl / 2) * (p + 1) + p);
    check({"R7 change strobe count ", tag}, chgn, 1);
    check({"R8 sample strobe position ", tag}, smpi, (th / 2) * (p + 1) + p);
    check({"R8 sample strobe count ", tag}, smpn, 1);
  endtask

  task automatic watch(input int n, output int lows, output int chg, output int smp);
    lows = 0; chg = 0; smp = 0;
    repeat (n) begin
      if (scl_drive_low) lows++;
      if (sda_change_stb) chg++;
      if (sda_sample_stb) smp++;
      step();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int los[4];
    int his[3];
    int lows, chg, smp, cnt;
    los = '{0, 1, 2, 5};
    his = '{0, 1, 3};
    rst_n = 1'b0; mod_en = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'd0;
    seq_run = 1'b0; seq_hold = 1'b0; seq_rel = 1'b0;
    repeat (3) step();
    check("R5 reset SCL released", int'(scl_drive_low), 0);
    check("R5 reset strobes quiet", int'(sda_change_stb) + int'(sda_sample_stb), 0);
    rst_n = 1'b1;
    step();

    // Sweep of the timing settings
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 3; b++) begin
          program_cfg(p, los[a], his[b]);
          seq_run = 1'b1;
          check_period(p, los[a], his[b], $sformatf("p%0d l%0d h%0d", p, los[a], his[b]));
        end
      end
    end

    // R6: start latency from idle
    program_cfg(0, 0, 0);
    repeat (3) step();
    check("R6 idle before start", int'(scl_drive_low), 0);
    seq_run = 1'b1;
    step();
    check("R6 low one cycle after run", int'(scl_drive_low), 1);

    // R9: hold extends the low phase
    program_cfg(0, 0, 0);
    seq_hold = 1'b1; seq_run = 1'b1;
    step();
    watch(30, lows, chg, smp);
    check("R9 SCL held low", lows, 30);
    check("R9 single change strobe while held", chg, 1);
    seq_hold = 1'b0;
    step();
    check("R9 released after hold drops", int'(scl_drive_low), 0);

    // R10: release beats hold at the end of a low phase
    program_cfg(1, 2, 0);
    seq_run = 1'b1;
    step();
    seq_rel = 1'b1; seq_hold = 1'b1;
    cnt = 0;
    while (scl_drive_low && cnt < 100) begin cnt++; step(); end
    check("R10 low completes before release", cnt, 18);
    watch(30, lows, chg, smp);
    check("R10 stays idle while released", lows, 0);
    seq_rel = 1'b0; seq_hold = 1'b0;
    step();
    check("R10 restart after release drops", int'(scl_drive_low), 1);
    while (scl_drive_low) step();
    seq_rel = 1'b1;
    watch(40, lows, chg, smp);
    check("R10 release from high stays idle", lows, 0);
    check("R10 high phase still sampled", smp, 1);
    seq_rel = 1'b0;

    // R11: run dropped during low finishes the period then idles
    program_cfg(0, 0, 1);
    seq_run = 1'b1;
    step();
    seq_run = 1'b0;
    cnt = 0;
    while (scl_drive_low && cnt < 100) begin cnt++; step(); end
    check("R11 low phase completes", cnt, 7);
    watch(30, lows, chg, smp);
    check("R11 idle after high", lows, 0);
    check("R11 high phase sampled once", smp, 1);

    // R4: writes while enabled are ignored
    program_cfg(0, 0, 0);
    seq_run = 1'b1;
    write_reg(2'd0, 3);
    write_reg(2'd1, 9);
    write_reg(2'd2, 9);
    check_period(0, 0, 0, "R4 enabled writes ignored");
    program_cfg(1, 1, 1);
    mod_en = 1'b0;
    step();
    write_reg(2'd3, 8'h55);
    mod_en = 1'b1; seq_run = 1'b1;
    check_period(1, 1, 1, "R4 selector 3 ignored");

    // R5: enable drop mid-low, settings retained
    step(); step();
    check("R5 running before disable", int'(scl_drive_low), 1);
    mod_en = 1'b0;
    step();
    check("R5 released after disable", int'(scl_drive_low), 0);
    watch(10, lows, chg, smp);
    check("R5 quiet while disabled", lows + chg + smp, 0);
    mod_en = 1'b1;
    check_period(1, 1, 1, "R5 settings retained");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule